// File: doc/BRIEF.md
# Prioritised Maskable Interrupt Controller

This block gathers level-sensitive, synchronous request lines from up to sixteen devices and one non-maskable source and reports a single interrupt to the processor. With the interrupt it gives the identifier of the device that should be serviced first. Each device request is caught in a pending latch. The latch stays set until software writes that device's identifier to an acknowledge register. A pending device is eligible only when its own mask bit is clear and the global enable is set.

Each source is mapped to a 4-bit priority level through a software-writable table. A larger level number means a higher priority. Among eligible sources the one with the highest level wins. When levels are equal, the lower source index wins. The non-maskable source ignores every mask and the global enable, and it always takes precedence with the reserved identifier 31. The winner is recomputed every cycle and registered onto the outputs.

Software reaches the configuration through a small word-addressed register port with a write strobe and a combinational read path. The register map is:

- 0: control (bit 0 is the global enable)
- 1: mask (bit i masks source i)
- 2: acknowledge (write-only; reads as 0)
- 3: pending (read-only)
- 4 and up: the priority table

Top module: `irq_ctrl`

## Requirements
- R1: After reset, irq_o is 0 and irq_id_o is 0. The control, mask and priority registers also read back as 0.
- R2: A high request on source i at a clock edge sets pending bit i, and the bit stays set until it is acknowledged. The pending bits read back at address 3, with bit i for source i.
- R3: Writing value i (bits 4:0) to address 2 clears pending bit i at that edge, unless request i is high in the same cycle, in which case the bit stays set.
- R4: A pending source is eligible only when its mask bit (address 1, bit i, 1 = masked) is 0 and the global enable (address 0, bit 0) is 1. Ineligible sources never raise irq_o.
- R5: irq_o and irq_id_o are registered. On each edge they take the result computed from the state that held before that edge. irq_id_o is 0 whenever irq_o is 0.
- R6: Among eligible sources, the one with the numerically largest priority level is reported.
- R7: When eligible sources share the largest level, the lowest source index is reported.
- R8: The level of source i is held in 4 bits at address 4 + i/8, bits [4*(i%8)+3 : 4*(i%8)]. These fields are writable and read back, and a new value changes the arbitration.
- R9: When the non-maskable input is high at an edge, the next edge sets irq_o to 1 and irq_id_o to 31, whatever the masks, the enable and the pending state.
- R10: An acknowledge write of a value that names no source (16 to 31) leaves all pending bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 16 | Level request per device |
| nmi_i | input | 1 | Non-maskable request |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt flag to the processor |
| irq_id_o | output | 5 | Identifier of the reported source |

## Verification
Directed patterns separate the main cases, each of which would hide a different fault:

- a single request while the global enable is off, then on
- two simultaneous requests at equal level, which isolates the low-index tie rule
- one of those requests lifted to a higher level, which isolates level ordering and the table's field placement
- the winner masked, which shows the fall-back to the next candidate
- an acknowledge for an out-of-range identifier
- an acknowledge that coincides with a still-high request
- the non-maskable input raised while the enable is off

A long run of sparse random requests, mixed with random writes to the control, mask, acknowledge and table registers, is then compared cycle by cycle against a bench model. That model searches the levels from the top down rather than scanning the sources.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 4'd0,
    REG_MASK  = 4'd1,
    REG_ACK   = 4'd2,
    REG_PEND  = 4'd3,
    REG_PRIO0 = 4'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int N_SRC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q;

  // request wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= req_i | (pend_q & ~clr_i);
  end

  assign pend_o = pend_q;

  a_r2_pending_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_q & ~clr_i) & ~pend_q) == '0));

  a_r3_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(clr_i & ~req_i)) == '0));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int N_SRC  = 16,
  parameter int LVL_W  = 4,
  parameter int ID_W   = 5,
  parameter int DATA_W = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic [N_SRC-1:0]             pend_i,
  output logic                         en_o,
  output logic [N_SRC-1:0]             mask_o,
  output logic [N_SRC-1:0][LVL_W-1:0]  lvl_o,
  output logic [N_SRC-1:0]             clr_o,
  output logic [DATA_W-1:0]            rdata_o
);
  localparam int PER_WORD = DATA_W / LVL_W;
  localparam int N_WORDS  = (N_SRC + PER_WORD - 1) / PER_WORD;

  logic                        en_q;
  logic [N_SRC-1:0]            mask_q;
  logic [N_SRC-1:0][LVL_W-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mask_q <= '0;
    end else if (we_i) begin
      if (addr_i == REG_CTRL) en_q   <= wdata_i[0];
      if (addr_i == REG_MASK) mask_q <= wdata_i[N_SRC-1:0];
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam int WORD = i / PER_WORD;
    localparam int SLOT = i % PER_WORD;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q[i] <= '0;
      else if (we_i && addr_i == ADDR_W'(REG_PRIO0 + WORD))
        lvl_q[i] <= wdata_i[SLOT*LVL_W +: LVL_W];
    end

    assign clr_o[i] = we_i && (addr_i == REG_ACK) &&
                      (wdata_i[ID_W-1:0] == ID_W'(i));
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL: rdata_o[0]         = en_q;
      REG_MASK: rdata_o[N_SRC-1:0] = mask_q;
      REG_PEND: rdata_o[N_SRC-1:0] = pend_i;
      default: begin
        for (int w = 0; w < N_WORDS; w++) begin
          if (addr_i == ADDR_W'(REG_PRIO0 + w)) begin
            for (int j = 0; j < PER_WORD; j++) begin
              if (w * PER_WORD + j < N_SRC)
                rdata_o[j*LVL_W +: LVL_W] = lvl_q[w*PER_WORD + j];
            end
          end
        end
      end
    endcase
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign lvl_o  = lvl_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC = 16,
  parameter int LVL_W = 4,
  parameter int ID_W  = 5
) (
  input  logic [N_SRC-1:0]            elig_i,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl_i,
  output logic                        valid_o,
  output logic [ID_W-1:0]             id_o
);
  logic [LVL_W-1:0] best_lvl;

  // scan downward with >= so that ties settle on the lowest index
  always_comb begin
    valid_o  = 1'b0;
    best_lvl = '0;
    id_o     = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig_i[i] && (!valid_o || lvl_i[i] >= best_lvl)) begin
        valid_o  = 1'b1;
        best_lvl = lvl_i[i];
        id_o     = ID_W'(i);
      end
    end
  end

  always_comb begin
    if (valid_o) begin
      for (int k = 0; k < N_SRC; k++) begin
        if (elig_i[k]) begin
          a_r6_no_higher_level: assert (lvl_i[k] <= best_lvl);
          if (lvl_i[k] == best_lvl)
            a_r7_low_index_tie: assert (ID_W'(k) >= id_o);
        end
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC  = 16,
  parameter int LVL_W  = 4,
  parameter int ID_W   = 5,
  parameter int DATA_W = 32,
  parameter int NMI_ID = 31
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_SRC-1:0]     irq_req_i,
  input  logic                 nmi_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic                 irq_o,
  output logic [ID_W-1:0]      irq_id_o
);
  logic                        en;
  logic [N_SRC-1:0]            mask, clr, pend, elig;
  logic [N_SRC-1:0][LVL_W-1:0] lvl;
  logic                        win_valid;
  logic [ID_W-1:0]             win_id;
  logic                        nmi_q, irq_q;
  logic [ID_W-1:0]             id_q;

  irq_regs #(.N_SRC(N_SRC), .LVL_W(LVL_W), .ID_W(ID_W), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .pend_i  (pend),
    .en_o    (en),
    .mask_o  (mask),
    .lvl_o   (lvl),
    .clr_o   (clr),
    .rdata_o (reg_rdata_o)
  );

  irq_pending #(.N_SRC(N_SRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (irq_req_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  assign elig = pend & ~mask & {N_SRC{en}};

  irq_arbiter #(.N_SRC(N_SRC), .LVL_W(LVL_W), .ID_W(ID_W)) u_arb (
    .elig_i  (elig),
    .lvl_i   (lvl),
    .valid_o (win_valid),
    .id_o    (win_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q <= 1'b0;
      irq_q <= 1'b0;
      id_q  <= '0;
    end else begin
      nmi_q <= nmi_i;
      irq_q <= nmi_q | win_valid;
      if (nmi_q)          id_q <= ID_W'(NMI_ID);
      else if (win_valid) id_q <= win_id;
      else                id_q <= '0;
    end
  end

  assign irq_o    = irq_q;
  assign irq_id_o = id_q;

  a_r9_nmi_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_q |=> (irq_o && irq_id_o == ID_W'(NMI_ID)));

  a_r5_idle_id_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (irq_id_o == '0));

  a_r4_enable_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !nmi_q) |=> !irq_o);
endmodule

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [15:0] irq_req_i;
  logic        nmi_i;
  logic        reg_we_i;
  logic [3:0]  reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic        irq_o;
  logic [4:0]  irq_id_o;

  int checks = 0;
  int fails  = 0;

  logic        m_en, m_nmi_q, e_irq;
  logic [15:0] m_mask, m_pend;
  logic [3:0]  m_lvl [16];
  logic [4:0]  e_id;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_ctrl dut (
    .clk_i, .rst_ni, .irq_req_i, .nmi_i, .reg_we_i, .reg_addr_i,
    .reg_wdata_i, .reg_rdata_o, .irq_o, .irq_id_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // level-first search: top level down, lowest index first
  function automatic logic [5:0] model_out();
    if (m_nmi_q) return {1'b1, 5'd31};
    for (int l = 15; l >= 0; l--)
      for (int s = 0; s < 16; s++)
        if (m_en && m_pend[s] && !m_mask[s] && m_lvl[s] == 4'(l))
          return {1'b1, 5'(s)};
    return 6'd0;
  endfunction

  function automatic logic [31:0] model_read(input logic [3:0] a);
    logic [31:0] r = '0;
    case (a)
      4'd0: r[0] = m_en;
      4'd1: r[15:0] = m_mask;
      4'd3: r[15:0] = m_pend;
      4'd4, 4'd5: for (int j = 0; j < 8; j++) r[4*j +: 4] = m_lvl[(a - 4)*8 + j];
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic cyc(input logic [15:0] req, input logic nmi, input logic we,
                     input logic [3:0] a, input logic [31:0] wd, input string tag);
    logic [15:0] clr = '0;
    logic [5:0]  o;
    irq_req_i = req; nmi_i = nmi; reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd;
    @(posedge clk_i);
    o = model_out();
    e_irq = o[5]; e_id = o[4:0];
    if (we) begin
      case (a)
        4'd0: m_en = wd[0];
        4'd1: m_mask = wd[15:0];
        4'd2: if (wd[4:0] < 5'd16) clr[wd[3:0]] = 1'b1;
        4'd4, 4'd5: for (int j = 0; j < 8; j++) m_lvl[(a - 4)*8 + j] = wd[4*j +: 4];
        default: ;
      endcase
    end
    m_pend  = req | (m_pend & ~clr);
    m_nmi_q = nmi;
    @(negedge clk_i);
    chk({tag, " irq"}, 32'(irq_o), 32'(e_irq));
    chk({tag, " id"},  32'(irq_id_o), 32'(e_id));
  endtask

  task automatic idle(input string tag);
    cyc(16'h0, 1'b0, 1'b0, 4'd0, 32'h0, tag);
  endtask

  task automatic rd_chk(input logic [3:0] a, input string tag);
    reg_we_i = 1'b0; reg_addr_i = a;
    #1;
    chk({tag, " read"}, reg_rdata_o, model_read(a));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL R5: watchdog expired, actual hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] ra;
    void'($urandom(32'd1234));
    rst_ni = 1'b0; irq_req_i = '0; nmi_i = 1'b0;
    reg_we_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
    m_en = 0; m_nmi_q = 0; m_mask = '0; m_pend = '0;
    for (int i = 0; i < 16; i++) m_lvl[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 id", 32'(irq_id_o), 0);
    rd_chk(4'd0, "R1"); rd_chk(4'd1, "R1"); rd_chk(4'd4, "R1"); rd_chk(4'd5, "R1");

    // R4/R2: request with enable off stays silent but latches
    cyc(16'h0008, 0, 0, 4'd0, 0, "R4");
    idle("R4"); idle("R4");
    rd_chk(4'd3, "R2");
    cyc(16'h0, 0, 1, 4'd0, 32'h1, "R4");
    idle("R5"); idle("R5");
    // R7: equal levels, lowest index
    cyc(16'h0220, 0, 0, 4'd0, 0, "R7");
    idle("R7");
    cyc(16'h0, 0, 1, 4'd2, 32'd3, "R3");
    idle("R7"); idle("R7");
    // R6/R8: lift source 9 to level 7
    cyc(16'h0, 0, 1, 4'd5, 32'h0000_0070, "R8");
    idle("R6"); idle("R6");
    rd_chk(4'd5, "R8");
    // R4: mask source 9
    cyc(16'h0, 0, 1, 4'd1, 32'h0000_0200, "R4");
    idle("R4"); idle("R4");
    // R10: out-of-range acknowledges
    cyc(16'h0, 0, 1, 4'd2, 32'd20, "R10");
    idle("R10");
    rd_chk(4'd3, "R10");
    cyc(16'h0, 0, 1, 4'd2, 32'd31, "R10");
    rd_chk(4'd3, "R10");
    // R3: acknowledge while request still high
    cyc(16'h0020, 0, 1, 4'd2, 32'd5, "R3");
    idle("R3");
    rd_chk(4'd3, "R3");
    // R9: non-maskable with enable off
    cyc(16'h0, 0, 1, 4'd0, 32'h0, "R4");
    cyc(16'h0, 1, 0, 4'd0, 0, "R9");
    idle("R9"); idle("R9"); idle("R9");
    cyc(16'h0, 0, 1, 4'd0, 32'h1, "R5");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [15:0] rq;
      logic        wr;
      logic [31:0] wd;
      int          sel;
      rq  = 16'($urandom) & 16'($urandom) & 16'($urandom);
      wr  = ($urandom % 3) == 0;
      sel = $urandom % 6;
      case (sel)
        0: begin ra = 4'd0; wd = 32'(($urandom % 5) != 0); end
        1: begin ra = 4'd1; wd = 32'($urandom & $urandom & 32'hffff); end
        2, 3: begin ra = 4'd2; wd = 32'($urandom % 20); end
        4: begin ra = 4'd4; wd = $urandom; end
        default: begin ra = 4'd5; wd = $urandom; end
      endcase
      cyc(rq, ($urandom % 25) == 0, wr, ra, wd, "R6");
      if (($urandom % 8) == 0) rd_chk(4'd3, "R2");
      if (($urandom % 16) == 0) rd_chk(4'(4 + ($urandom % 2)), "R8");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule